// File: doc/BRIEF.md
# Reloadable Interval Timer with Snapshot Readback

This block is a down-counting interval timer that sits on an 8-bit register bus. On each system clock cycle where the timer tick enable is high, the count drops by one. A tick that finds the count at zero reloads it from a 12-bit reload register and raises a one-cycle interrupt request to an external interrupt controller. The timer period is therefore the reload value plus one ticks.

Software reads the 12-bit count as two bytes. Reading the low count byte returns the live bits [7:0] and, in the same access, freezes bits [11:8] into a snapshot. A later read of the high count register returns that snapshot, so the two bytes always belong to the same count value. The reload value is written low byte first and high nibble second. The low byte waits in a staging register, and both halves take effect together when the high nibble is written. The counter therefore never reloads from a half-written value.

Register offsets: 0x26 count low (read), 0x27 count high snapshot (read), 0x28 reload low (read/write), 0x29 reload high (read/write, bits [3:0]). Bus reads are combinational from `bus_addr_i`. The side effect of a read, and every write, takes place on the clock edge where `bus_rd_i` or `bus_wr_i` is high.

Top module: `interval_timer`

## Requirements
- R1: After reset the count, the committed reload value, the reload staging byte and the snapshot are all zero, and `irq_o` is low.
- R2: The count changes only on cycles where `tick_i` is high. On such a cycle with a nonzero count it decreases by exactly one.
- R3: A tick that finds the count at zero loads the committed reload value and drives `irq_o` high for exactly the following clock cycle. Wraps are therefore reload+1 ticks apart.
- R4: A read of offset 0x26 returns count bits [7:0] as they stand before that edge. The same read copies count bits [11:8] into the snapshot.
- R5: A read of offset 0x27 returns the snapshot in bits [3:0], with bits [7:4] zero. The snapshot changes only on a read of 0x26, whatever the counter does.
- R6: A write to offset 0x28 only loads the staging byte and leaves the committed reload value unchanged. A write to offset 0x29 sets the committed reload value to {wdata[3:0], staging byte}.
- R7: A read of offset 0x28 returns committed reload bits [7:0]. A read of 0x29 returns committed reload bits [11:8] in bits [3:0], with bits [7:4] zero.
- R8: Writes to offsets 0x26 and 0x27 change no state. Write data bits [7:4] at offset 0x29 are ignored.
- R9: A read of any offset other than 0x26 to 0x29 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable; one count step per high cycle |
| bus_addr_i | input | 8 | Register offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; triggers the snapshot at 0x26 |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the offset |
| irq_o | output | 1 | One-cycle interrupt request per wrap |

## Verification
The bench uses the default 12-bit count, 8-bit data and the default offsets. With these values a reload of 0x100 makes the high nibble change between a low-byte read and a later high read, so a stale snapshot can be told apart from the live value. The reload values of 0x234 and 0x100 need several hundred ticks to drain, and they test the staging path across a full wrap. A small reload of 5 under a continuous tick stream checks wrap spacing and pulse width.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned CNT_W_DEF  = 12;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 8;

  localparam logic [7:0] OFF_CNT_LO = 8'h26;
  localparam logic [7:0] OFF_CNT_HI = 8'h27;
  localparam logic [7:0] OFF_RLD_LO = 8'h28;
  localparam logic [7:0] OFF_RLD_HI = 8'h29;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic rld_lo;
    logic rld_hi;
  } ivt_sel_t;
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
  import ivt_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO),
  parameter logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI),
  parameter logic [ADDR_W-1:0] A_RLD_LO = ADDR_W'(OFF_RLD_LO),
  parameter logic [ADDR_W-1:0] A_RLD_HI = ADDR_W'(OFF_RLD_HI)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output ivt_sel_t          sel_o
);
  always_comb begin
    sel_o        = '0;
    sel_o.cnt_lo = (addr_i == A_CNT_LO);
    sel_o.cnt_hi = (addr_i == A_CNT_HI);
    sel_o.rld_lo = (addr_i == A_RLD_LO);
    sel_o.rld_hi = (addr_i == A_RLD_HI);
  end
endmodule

// File: rtl/ivt_reload.sv
module ivt_reload #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  reload_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] stage_q;
  logic [CNT_W-1:0]  reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (wr_lo_i) begin
      stage_q <= wdata_i;
    end
  end

  // commit both halves together; upper wdata bits are reserved
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
    end else if (wr_hi_i) begin
      reload_q <= {wdata_i[HI_W-1:0], stage_q};
    end
  end

  assign reload_o = reload_q;

  AST_RELOAD_ONLY_ON_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hi_i |=> $stable(reload_o)); // R6
  AST_STAGE_ONLY_ON_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lo_i |=> $stable(stage_q)); // R6
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= tick_i & at_zero;
      if (tick_i) begin
        cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R2
  AST_WRAP_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_o == '0) |=> (cnt_o == $past(reload_i))); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_o == '0) |=> irq_o); // R3
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && cnt_o == '0) |=> !irq_o); // R3
endmodule

// File: rtl/ivt_readback.sv
module ivt_readback
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  ivt_sel_t          sel_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  reload_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HI_W  = CNT_W - DATA_W;
  localparam int unsigned PAD_W = DATA_W - HI_W;

  logic [HI_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
    end else if (rd_i && sel_i.cnt_lo) begin
      snap_q <= cnt_i[CNT_W-1:DATA_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i.cnt_lo)      rdata_o = cnt_i[DATA_W-1:0];
    else if (sel_i.cnt_hi) rdata_o = {{PAD_W{1'b0}}, snap_q};
    else if (sel_i.rld_lo) rdata_o = reload_i[DATA_W-1:0];
    else if (sel_i.rld_hi) rdata_o = {{PAD_W{1'b0}}, reload_i[CNT_W-1:DATA_W]};
  end

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && sel_i.cnt_lo) |=> $stable(snap_q)); // R5
  AST_SNAP_TAKES_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i.cnt_lo) |=> (snap_q == $past(cnt_i[CNT_W-1:DATA_W]))); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.cnt_hi || sel_i.rld_hi) |-> (rdata_o[DATA_W-1:HI_W] == '0)); // R5
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  ivt_sel_t         sel;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;

  ivt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  ivt_reload #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_reload (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_lo_i  (bus_wr_i & sel.rld_lo),
    .wr_hi_i  (bus_wr_i & sel.rld_hi),
    .wdata_i  (bus_wdata_i),
    .reload_o (reload)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .reload_i (reload),
    .cnt_o    (cnt),
    .irq_o    (irq_o)
  );

  ivt_readback #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_readback (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (bus_rd_i),
    .sel_i    (sel),
    .cnt_i    (cnt),
    .reload_i (reload),
    .rdata_o  (bus_rdata_o)
  );

  AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && (sel.cnt_lo || sel.cnt_hi)) |=> $stable(reload)); // R8
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  localparam logic [3:0] OP_WR = 4'd1;
  localparam logic [3:0] OP_RD = 4'd2;
  localparam logic [3:0] OP_TK = 4'd3;
  localparam int N_VEC = 30;

  // {op, req, addr, data/ticks(12), expected rdata or irq count}
  localparam logic [35:0] VEC [N_VEC] = '{
    {OP_RD, 4'd1, 8'h26, 12'h000, 8'h00}, // R1
    {OP_RD, 4'd1, 8'h27, 12'h000, 8'h00}, // R1
    {OP_RD, 4'd1, 8'h28, 12'h000, 8'h00}, // R1
    {OP_RD, 4'd1, 8'h29, 12'h000, 8'h00}, // R1
    {OP_WR, 4'd6, 8'h28, 12'h034, 8'h00}, // R6 staged
    {OP_RD, 4'd6, 8'h28, 12'h000, 8'h00}, // R6 not yet committed
    {OP_WR, 4'd6, 8'h29, 12'h0F2, 8'h00}, // R6 commit, R8 upper bits
    {OP_RD, 4'd8, 8'h29, 12'h000, 8'h02}, // R8 R7
    {OP_RD, 4'd7, 8'h28, 12'h000, 8'h34}, // R7
    {OP_WR, 4'd8, 8'h26, 12'h0FF, 8'h00}, // R8
    {OP_WR, 4'd8, 8'h27, 12'h0FF, 8'h00}, // R8
    {OP_RD, 4'd8, 8'h26, 12'h000, 8'h00}, // R8 R2 no tick yet
    {OP_RD, 4'd9, 8'h5A, 12'h000, 8'h00}, // R9
    {OP_TK, 4'd3, 8'h00, 12'h001, 8'h01}, // R3 wrap loads 0x234
    {OP_RD, 4'd4, 8'h26, 12'h000, 8'h34}, // R4
    {OP_RD, 4'd5, 8'h27, 12'h000, 8'h02}, // R5
    {OP_TK, 4'd2, 8'h00, 12'h005, 8'h00}, // R2 -> 0x22F
    {OP_RD, 4'd4, 8'h26, 12'h000, 8'h2F}, // R4
    {OP_WR, 4'd6, 8'h28, 12'h000, 8'h00}, // R6
    {OP_WR, 4'd6, 8'h29, 12'h001, 8'h00}, // R6 reload 0x100
    {OP_TK, 4'd3, 8'h00, 12'h230, 8'h01}, // R3 -> 0x100
    {OP_RD, 4'd4, 8'h26, 12'h000, 8'h00}, // R4 snap=1
    {OP_TK, 4'd2, 8'h00, 12'h001, 8'h00}, // R2 -> 0x0FF
    {OP_RD, 4'd5, 8'h27, 12'h000, 8'h01}, // R5 stale snapshot
    {OP_RD, 4'd4, 8'h26, 12'h000, 8'hFF}, // R4 snap=0
    {OP_RD, 4'd5, 8'h27, 12'h000, 8'h00}, // R5
    {OP_WR, 4'd6, 8'h28, 12'h005, 8'h00}, // R6 staged only
    {OP_TK, 4'd3, 8'h00, 12'h100, 8'h01}, // R3 wrap uses old 0x100
    {OP_RD, 4'd6, 8'h26, 12'h000, 8'h00}, // R6
    {OP_RD, 4'd6, 8'h27, 12'h000, 8'h01}  // R6
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] bus_addr_i = '0;
  logic       bus_wr_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  interval_timer u_interval_timer (
    .clk_i, .rst_ni, .tick_i, .bus_addr_i, .bus_wr_i, .bus_rd_i,
    .bus_wdata_i, .bus_rdata_o, .irq_o
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #1 d = bus_rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic run_ticks(input int n, output int irqs);
    irqs = 0;
    @(negedge clk_i);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      tick_i = 1'b0;
      if (irq_o) irqs++;
    end
  endtask

  initial begin
    logic [7:0] rd;
    int irqs;
    int first_irq;
    int gap;
    repeat (3) @(negedge clk_i);
    check("R1 irq after reset", irq_o, 0);
    rst_ni = 1'b1;

    for (int v = 0; v < N_VEC; v++) begin
      logic [3:0]  op;
      logic [3:0]  rq;
      logic [7:0]  ad;
      logic [11:0] dt;
      logic [7:0]  ex;
      {op, rq, ad, dt, ex} = VEC[v];
      case (op)
        OP_WR: bus_write(ad, dt[7:0]);
        OP_RD: begin
          bus_read(ad, rd);
          check($sformatf("R%0d vec %0d read 0x%0h", rq, v, ad), rd, ex);
        end
        default: begin
          run_ticks(int'(dt), irqs);
          check($sformatf("R%0d vec %0d irq count", rq, v), irqs, ex);
        end
      endcase
    end

    // R3: commit reload 5, drain 0x100 -> 5, then check spacing and width
    bus_write(8'h29, 8'h00);
    run_ticks(257, irqs);
    check("R3 drain to reload 5", irqs, 1);
    first_irq = -1; gap = -1; irqs = 0;
    @(negedge clk_i);
    tick_i = 1'b1;
    for (int i = 1; i <= 14; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (irq_o) begin
        irqs++;
        if (first_irq < 0) first_irq = i;
        else if (gap < 0) gap = i - first_irq;
      end
    end
    tick_i = 1'b0;
    check("R3 wraps in 14 ticks", irqs, 2);
    check("R3 wrap spacing reload+1", gap, 6);
    @(negedge clk_i);
    check("R3 irq low without tick", irq_o, 0);

    // R2: idle cycles keep the count
    bus_read(8'h26, rd);
    repeat (5) @(negedge clk_i);
    begin
      logic [7:0] rd2;
      bus_read(8'h26, rd2);
      check("R2 count stable while idle", rd2, rd);
    end

    // R1: reset in mid-run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 irq in reset", irq_o, 0);
    rst_ni = 1'b1;
    bus_read(8'h28, rd); check("R1 reload low cleared", rd, 0);
    bus_read(8'h29, rd); check("R1 reload high cleared", rd, 0);
    bus_read(8'h27, rd); check("R1 snapshot cleared", rd, 0);
    bus_read(8'h26, rd); check("R1 count cleared", rd, 0);
    bus_write(8'h29, 8'h03);
    bus_read(8'h28, rd); check("R1 staging cleared", rd, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule